// File: doc/BRIEF.md
# Integer Width Conversion Unit

This block converts a 32-bit integer operand from one integer width and signedness to another. It selects a byte or halfword lane out of the operand, widens that lane to 32 bits, and can optionally take its absolute value and then negate it. The result is then either clamped into the range the destination format can hold (saturating mode) or cut down to the destination width (wrapping mode). The block reports a zero flag and a sign flag for the final value. It also raises an error output when a size code or lane selector is not supported.

The datapath is purely combinational. A parameter adds one output register stage, so the unit can sit inside a pipelined execution slot. Control fields arrive alongside the operand on every cycle. There is no handshake, and every cycle produces a new result.

Top module: `intconv_unit`

## Requirements
- R1: Size codes are 0 = byte (8 bits), 1 = halfword (16 bits), 2 = word (32 bits) and 3 = long (64 bits). The source lane starts at bit `lane_sel * 8` and is as wide as the source size. Byte sources accept lane_sel 0 to 3, halfword sources accept 0 or 2, and word sources accept only 0.
- R2: The extracted lane is sign-extended to 32 bits when `src_signed` is 1 and zero-extended when it is 0. A word source with lane 0 passes through unchanged.
- R3: Absolute value is applied first, and only to signed sources (a value with bit 31 set is negated). Negation (two's complement) is applied after it. Both act on the extended value before any clamp or mask.
- R4: With saturation on, a signed source and an unsigned destination: a value at or above 2^(s-1), compared unsigned for source width s, becomes 0. Then, for a byte or halfword destination, a value above 2^n − 1 becomes 2^n − 1.
- R5: With saturation on, a word source and a word destination of equal signedness give the value unchanged. If the signedness differs, the value is clamped to [0, 2^31 − 1].
- R6: In the remaining saturating cases, the compare uses the source signedness. A signed destination of n bits clamps to [−2^(n−1), 2^(n−1) − 1]. An unsigned destination clamps to [0, 2^n − 1], where the word upper bound is all ones. For an unsigned source, only the upper bound acts.
- R7: With saturation off and a byte or halfword destination, only the low n bits are kept and bits above them are 0, whatever the destination signedness. A word destination passes the value through.
- R8: `cfg_err` is 1 when either size is long or the lane selector is invalid for the source size. The conversion then uses lane 0, and any long size is treated as word.
- R9: `flag_zero` is 1 exactly when `result` is 0, and `flag_sign` equals `result[31]`.
- R10: With OUT_REG = 1, outputs appear one clock after the inputs. While reset is held, `result` is 0, `flag_zero` is 1, and `flag_sign` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| operand | input | 32 | Source operand |
| src_size | input | 2 | Source size code |
| dst_size | input | 2 | Destination size code |
| src_signed | input | 1 | Source is signed |
| dst_signed | input | 1 | Destination is signed |
| lane_sel | input | 2 | Byte offset of the source lane |
| abs_en | input | 1 | Take absolute value |
| neg_en | input | 1 | Negate after absolute value |
| sat_en | input | 1 | Saturate instead of wrapping |
| result | output | 32 | Converted value |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Bit 31 of result |
| cfg_err | output | 1 | Unsupported size or selector |

## Verification
The bench builds the unit with its defaults, DATA_W = 32 and OUT_REG = 1. This brings the registered path and its reset values into reach, and every result is checked one clock after it is driven. All sixteen size pairs, both signedness bits, every lane selector and all mode flags are reachable. This lets random stimulus hit the wrap and clamp paths, the long and bad-selector error fallbacks, and the abs and negate edge values such as the most negative lane value.

// File: rtl/intconv_pkg.sv
// Shared size encoding and helpers for the integer width conversion unit.
// Assumes a 32-bit datapath; long is recognised only to be rejected.
package intconv_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } size_e;

    localparam int unsigned LANE_W = 8;

    // Largest unsigned value a size can hold (word and above: all ones).
    function automatic logic [31:0] umax_of(input size_e sz);
        case (sz)
            SZ_BYTE: umax_of = 32'h0000_00FF;
            SZ_HALF: umax_of = 32'h0000_FFFF;
            default: umax_of = 32'hFFFF_FFFF;
        endcase
    endfunction

    // Largest signed value a size can hold.
    function automatic logic [31:0] smax_of(input size_e sz);
        case (sz)
            SZ_BYTE: smax_of = 32'h0000_007F;
            SZ_HALF: smax_of = 32'h0000_7FFF;
            default: smax_of = 32'h7FFF_FFFF;
        endcase
    endfunction

    // Smallest signed value a size can hold, as a 32-bit pattern.
    function automatic logic [31:0] smin_of(input size_e sz);
        case (sz)
            SZ_BYTE: smin_of = 32'hFFFF_FF80;
            SZ_HALF: smin_of = 32'hFFFF_8000;
            default: smin_of = 32'h8000_0000;
        endcase
    endfunction

    // Weight of the top bit of a size, i.e. 2^(n-1).
    function automatic logic [31:0] topbit_of(input size_e sz);
        case (sz)
            SZ_BYTE: topbit_of = 32'h0000_0080;
            SZ_HALF: topbit_of = 32'h0000_8000;
            default: topbit_of = 32'h8000_0000;
        endcase
    endfunction

endpackage

// File: rtl/intconv_cfg.sv
// Validates the size codes and lane selector.
// Outputs effective sizes (long folded to word) and the effective selector
// (forced to 0 on any error). Purely combinational.
module intconv_cfg
    import intconv_pkg::*;
(
    input  logic [1:0] src_size,
    input  logic [1:0] dst_size,
    input  logic [1:0] lane_sel,
    output size_e      eff_src,
    output size_e      eff_dst,
    output logic [1:0] eff_sel,
    output logic       bad
);

    logic size_bad;
    logic sel_bad;

    // Detect unsupported sizes and selectors that do not fit the source size.
    always_comb begin
        size_bad = (size_e'(src_size) == SZ_LONG) || (size_e'(dst_size) == SZ_LONG);
        case (size_e'(src_size))
            SZ_BYTE: sel_bad = 1'b0;
            SZ_HALF: sel_bad = lane_sel[0];
            default: sel_bad = (lane_sel != 2'd0);
        endcase
        bad = size_bad || sel_bad;
    end

    // Fold long to word and fall back to lane 0 when the configuration is bad.
    always_comb begin
        eff_src = (size_e'(src_size) == SZ_LONG) ? SZ_WORD : size_e'(src_size);
        eff_dst = (size_e'(dst_size) == SZ_LONG) ? SZ_WORD : size_e'(dst_size);
        eff_sel = bad ? 2'd0 : lane_sel;
    end

endmodule

// File: rtl/intconv_lane.sv
// Extracts the selected byte or halfword lane and widens it to DATA_W bits,
// sign- or zero-extending by the source signedness. Word sources pass through.
// Assumes the selector has already been validated.
module intconv_lane
    import intconv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] operand,
    input  size_e             src_sz,
    input  logic [1:0]        sel,
    input  logic              is_signed,
    output logic [DATA_W-1:0] ext_val
);

    localparam int unsigned HALF_W = 2 * LANE_W;

    logic [DATA_W-1:0] shifted;
    logic [LANE_W-1:0] byte_f;
    logic [HALF_W-1:0] half_f;

    // Move the chosen lane down to bit 0.
    always_comb begin
        shifted = operand >> (sel * LANE_W);
        byte_f  = shifted[LANE_W-1:0];
        half_f  = shifted[HALF_W-1:0];
    end

    // Widen the lane by the source signedness.
    always_comb begin
        case (src_sz)
            SZ_BYTE: ext_val = {{(DATA_W-LANE_W){is_signed & byte_f[LANE_W-1]}}, byte_f};
            SZ_HALF: ext_val = {{(DATA_W-HALF_W){is_signed & half_f[HALF_W-1]}}, half_f};
            default: ext_val = operand;
        endcase
    end

endmodule

// File: rtl/intconv_absneg.sv
// Applies the optional absolute value (signed sources only), then the optional
// two's complement negation. Combinational.
module intconv_absneg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_val,
    input  logic              is_signed,
    input  logic              abs_en,
    input  logic              neg_en,
    output logic [DATA_W-1:0] out_val
);

    logic [DATA_W-1:0] abs_val;

    // Absolute value: only a signed value with its top bit set changes.
    always_comb begin
        if (abs_en && is_signed && in_val[DATA_W-1])
            abs_val = -in_val;
        else
            abs_val = in_val;
    end

    // Negation follows the absolute value.
    always_comb begin
        out_val = neg_en ? -abs_val : abs_val;
    end

endmodule

// File: rtl/intconv_clamp.sv
// Final range stage. With saturation it clamps into the destination range,
// comparing with the source signedness. Without it, it masks narrow
// destinations to their width. Assumes 32-bit values and sizes with long
// already folded to word.
module intconv_clamp
    import intconv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_val,
    input  size_e             src_sz,
    input  size_e             dst_sz,
    input  logic              src_signed,
    input  logic              dst_signed,
    input  logic              sat_en,
    output logic [DATA_W-1:0] out_val
);

    logic [DATA_W-1:0] d_umax;
    logic [DATA_W-1:0] d_smax;
    logic [DATA_W-1:0] d_smin;
    logic [DATA_W-1:0] s_top;
    logic              dst_narrow;
    logic              both_word;
    logic [DATA_W-1:0] s2u_floor;
    logic [DATA_W-1:0] s2u_val;
    logic [DATA_W-1:0] ww_val;
    logic [DATA_W-1:0] sdst_val;
    logic [DATA_W-1:0] udst_val;
    logic [DATA_W-1:0] wrap_val;

    // Range constants for the current sizes.
    always_comb begin
        d_umax     = umax_of(dst_sz);
        d_smax     = smax_of(dst_sz);
        d_smin     = smin_of(dst_sz);
        s_top      = topbit_of(src_sz);
        dst_narrow = (dst_sz != SZ_WORD);
        both_word  = (src_sz == SZ_WORD) && (dst_sz == SZ_WORD);
    end

    // Signed source into unsigned destination: negatives to zero, then upper bound.
    always_comb begin
        s2u_floor = (in_val >= s_top) ? '0 : in_val;
        if (dst_narrow && (s2u_floor > d_umax))
            s2u_val = d_umax;
        else
            s2u_val = s2u_floor;
    end

    // Word into word: clamp only when the signedness differs.
    always_comb begin
        if (src_signed == dst_signed)
            ww_val = in_val;
        else if (in_val > d_smax)
            ww_val = d_smax;
        else
            ww_val = in_val;
    end

    // Signed destination: a signed source uses both bounds, an unsigned one the upper bound.
    always_comb begin
        if (src_signed) begin
            if ($signed(in_val) < $signed(d_smin))
                sdst_val = d_smin;
            else if ($signed(in_val) > $signed(d_smax))
                sdst_val = d_smax;
            else
                sdst_val = in_val;
        end else begin
            sdst_val = (in_val > d_smax) ? d_smax : in_val;
        end
    end

    // Unsigned destination from an unsigned source: upper bound only.
    always_comb begin
        udst_val = (in_val > d_umax) ? d_umax : in_val;
    end

    // Wrapping mode: keep the low destination bits.
    always_comb begin
        wrap_val = dst_narrow ? (in_val & d_umax) : in_val;
    end

    // Select the path for the current mode.
    always_comb begin
        if (!sat_en)
            out_val = wrap_val;
        else if (src_signed && !dst_signed)
            out_val = s2u_val;
        else if (both_word)
            out_val = ww_val;
        else if (dst_signed)
            out_val = sdst_val;
        else
            out_val = udst_val;
    end

endmodule

// File: rtl/intconv_unit.sv
// Integer width conversion unit top level. It chains configuration checking,
// lane extraction, abs/negate and clamp/mask, then derives the flags. With
// OUT_REG = 1, the outputs are registered once (synchronous active-low reset).
// With OUT_REG = 0, the outputs are combinational.
module intconv_unit
    import intconv_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned OUT_REG = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] operand,
    input  logic [1:0]  src_size,
    input  logic [1:0]  dst_size,
    input  logic        src_signed,
    input  logic        dst_signed,
    input  logic [1:0]  lane_sel,
    input  logic        abs_en,
    input  logic        neg_en,
    input  logic        sat_en,
    output logic [31:0] result,
    output logic        flag_zero,
    output logic        flag_sign,
    output logic        cfg_err
);

    localparam int unsigned MSB = DATA_W - 1;

    size_e             eff_src;
    size_e             eff_dst;
    logic [1:0]        eff_sel;
    logic              bad;
    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] an_val;
    logic [DATA_W-1:0] conv_val;
    logic              zero_c;
    logic              sign_c;

    intconv_cfg u_cfg (
        .src_size (src_size),
        .dst_size (dst_size),
        .lane_sel (lane_sel),
        .eff_src  (eff_src),
        .eff_dst  (eff_dst),
        .eff_sel  (eff_sel),
        .bad      (bad)
    );

    intconv_lane #(.DATA_W(DATA_W)) u_lane (
        .operand   (operand),
        .src_sz    (eff_src),
        .sel       (eff_sel),
        .is_signed (src_signed),
        .ext_val   (ext_val)
    );

    intconv_absneg #(.DATA_W(DATA_W)) u_absneg (
        .in_val    (ext_val),
        .is_signed (src_signed),
        .abs_en    (abs_en),
        .neg_en    (neg_en),
        .out_val   (an_val)
    );

    intconv_clamp #(.DATA_W(DATA_W)) u_clamp (
        .in_val     (an_val),
        .src_sz     (eff_src),
        .dst_sz     (eff_dst),
        .src_signed (src_signed),
        .dst_signed (dst_signed),
        .sat_en     (sat_en),
        .out_val    (conv_val)
    );

    // Condition flags from the final value.
    always_comb begin
        zero_c = (conv_val == '0);
        sign_c = conv_val[MSB];
    end

    generate
        if (OUT_REG != 0) begin : g_reg
            // Output stage: register the result, flags and error.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result    <= '0;
                    flag_zero <= 1'b1;
                    flag_sign <= 1'b0;
                    cfg_err   <= 1'b0;
                end else begin
                    result    <= conv_val;
                    flag_zero <= zero_c;
                    flag_sign <= sign_c;
                    cfg_err   <= bad;
                end
            end
        end else begin : g_comb
            // Pass-through outputs when no register stage is wanted.
            always_comb begin
                result    = conv_val;
                flag_zero = zero_c;
                flag_sign = sign_c;
                cfg_err   = bad;
            end
        end
    endgenerate

    // A long size on either side must be reported.
    p_long_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_size == 2'd3) || (dst_size == 2'd3)) |-> bad);

    // Wrapping into a byte leaves nothing above bit 7.
    p_wrap_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_en && (dst_size == 2'd0)) |-> (conv_val[31:8] == 24'd0));

    // Signed-to-unsigned saturation never yields a negative pattern.
    p_s2u_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && src_signed && !dst_signed) |-> !conv_val[MSB]);

    // Signed byte saturation of a signed source stays within the signed byte range.
    p_sbyte_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && src_signed && dst_signed && (dst_size == 2'd0))
        |-> ((conv_val[31:7] == '0) || (conv_val[31:7] == '1)));

    // Absolute value of a signed value is non-negative, except the most negative word.
    p_abs_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_en && !neg_en && src_signed && (ext_val != 32'h8000_0000)) |-> !an_val[MSB]);

    // Output flags agree with the output value.
    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero == (result == 32'd0));

    p_sign_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sign == result[31]);

endmodule

// File: tb/intconv_unit_test.sv
`timescale 1ns/1ps
module intconv_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] operand;
    logic [1:0]  src_size, dst_size, lane_sel;
    logic        src_signed, dst_signed, abs_en, neg_en, sat_en;
    logic [31:0] result;
    logic        flag_zero, flag_sign, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    intconv_unit uut (
        .clk(clk), .rst_n(rst_n), .operand(operand),
        .src_size(src_size), .dst_size(dst_size),
        .src_signed(src_signed), .dst_signed(dst_signed),
        .lane_sel(lane_sel), .abs_en(abs_en), .neg_en(neg_en), .sat_en(sat_en),
        .result(result), .flag_zero(flag_zero), .flag_sign(flag_sign), .cfg_err(cfg_err)
    );

    // Reference model written from the requirements.
    function automatic logic [31:0] model(input logic [31:0] op, input logic [1:0] s, d,
                                          input logic ss, ds, input logic [1:0] sel,
                                          input logic ab, ng, st, output logic err);
        logic [1:0]  es, ed, esel;
        logic [31:0] f, v, r, umax, hi, lo;
        int sb, db;
        err  = (s == 2'd3) || (d == 2'd3) || (s == 2'd1 && sel[0]) || (s >= 2'd2 && sel != 2'd0);
        es   = (s == 2'd3) ? 2'd2 : s;
        ed   = (d == 2'd3) ? 2'd2 : d;
        esel = err ? 2'd0 : sel;
        sb   = 8 << es;
        db   = 8 << ed;
        f    = op >> (esel * 8);
        if (sb == 8)       v = (ss && f[7])  ? (f | 32'hFFFF_FF00) : (f & 32'hFF);
        else if (sb == 16) v = (ss && f[15]) ? (f | 32'hFFFF_0000) : (f & 32'hFFFF);
        else               v = op;
        if (ab && ss && v[31]) v = -v;
        if (ng) v = -v;
        umax = (db == 32) ? 32'hFFFF_FFFF : ((32'd1 << db) - 1);
        if (!st) r = (db < 32) ? (v & umax) : v;
        else if (ss && !ds) begin
            r = (v >= (32'd1 << (sb - 1))) ? 32'd0 : v;
            if (db < 32 && r > umax) r = umax;
        end else if (sb == 32 && db == 32) begin
            r = (ss == ds) ? v : ((v > 32'h7FFF_FFFF) ? 32'h7FFF_FFFF : v);
        end else if (ds) begin
            hi = (32'd1 << (db - 1)) - 1;
            lo = ~hi;
            if (ss) r = ($signed(v) < $signed(lo)) ? lo : (($signed(v) > $signed(hi)) ? hi : v);
            else    r = (v > hi) ? hi : v;
        end else r = (v > umax) ? umax : v;
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one conversion, wait for the registered result, and compare it.
    task automatic run(input string tag, input logic [31:0] op, input logic [1:0] s, d,
                       input logic ss, ds, input logic [1:0] sel, input logic ab, ng, st,
                       input logic [31:0] exp_fixed, input bit use_fixed);
        logic e_err;
        logic [31:0] e;
        @(negedge clk);
        operand = op; src_size = s; dst_size = d; src_signed = ss; dst_signed = ds;
        lane_sel = sel; abs_en = ab; neg_en = ng; sat_en = st;
        e = model(op, s, d, ss, ds, sel, ab, ng, st, e_err);
        if (use_fixed) e = exp_fixed;
        @(negedge clk);
        check(tag, result, e);
        check({tag, " err"}, {31'd0, cfg_err}, {31'd0, e_err});
        check("R9 zero", {31'd0, flag_zero}, {31'd0, (e == 32'd0)});
        check("R9 sign", {31'd0, flag_sign}, {31'd0, e[31]});
    endtask

    function automatic string tag_of(input logic ss, ds, st, input logic [1:0] s, d);
        if (!st) return "R7 wrap";
        if (ss && !ds) return "R4 s2u";
        if (s >= 2'd2 && d >= 2'd2) return "R5 word";
        return "R6 sat";
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; operand = 32'hDEAD_BEEF; src_size = 0; dst_size = 0;
        src_signed = 1; dst_signed = 0; lane_sel = 0; abs_en = 0; neg_en = 0; sat_en = 1;
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10 reset result", result, 32'd0);
        check("R10 reset zero", {31'd0, flag_zero}, 32'd1);
        check("R10 reset sign/err", {30'd0, flag_sign, cfg_err}, 32'd0);
        rst_n = 1'b1;

        // R1: lane selection; R10 timing is covered by every run
        run("R1 byte lane3", 32'h1122_3344, 0, 2, 0, 0, 3, 0, 0, 0, 32'h0000_0011, 1);
        run("R1 half lane2", 32'h1122_3344, 1, 2, 0, 0, 2, 0, 0, 0, 32'h0000_1122, 1);
        // R2: extension
        run("R2 signed byte", 32'h00AB_0000, 0, 2, 1, 1, 2, 0, 0, 0, 32'hFFFF_FFAB, 1);
        run("R2 unsigned half", 32'h8000_1234, 1, 2, 0, 0, 2, 0, 0, 0, 32'h0000_8000, 1);
        run("R2 word pass", 32'h8765_4321, 2, 2, 1, 1, 0, 0, 0, 0, 32'h8765_4321, 1);
        // R3: abs / neg
        run("R3 abs signed", 32'h0000_00F0, 0, 2, 1, 1, 0, 1, 0, 0, 32'h0000_0010, 1);
        run("R3 abs neg", 32'h0000_00F0, 0, 2, 1, 1, 0, 1, 1, 0, 32'hFFFF_FFF0, 1);
        run("R3 abs unsigned", 32'h0000_00F0, 0, 2, 0, 0, 0, 1, 0, 0, 32'h0000_00F0, 1);
        // R4: signed to unsigned saturation
        run("R4 neg to zero", 32'h0000_0080, 0, 0, 1, 0, 0, 0, 0, 1, 32'h0000_0000, 1);
        run("R4 in range", 32'h0000_007F, 0, 0, 1, 0, 0, 0, 0, 1, 32'h0000_007F, 1);
        run("R4 upper clamp", 32'h0000_0300, 2, 0, 1, 0, 0, 0, 0, 1, 32'h0000_00FF, 1);
        run("R4 abs min byte", 32'h0000_0080, 0, 1, 1, 0, 0, 1, 0, 1, 32'h0000_0000, 1);
        // R5: word to word
        run("R5 same sign", 32'h8000_0000, 2, 2, 1, 1, 0, 0, 0, 1, 32'h8000_0000, 1);
        run("R5 u to s", 32'hFFFF_FFFF, 2, 2, 0, 1, 0, 0, 0, 1, 32'h7FFF_FFFF, 1);
        // R6: other clamps
        run("R6 s byte low", 32'hFFFF_FF00, 2, 0, 1, 1, 0, 0, 0, 1, 32'hFFFF_FF80, 1);
        run("R6 s byte high", 32'h0000_1000, 2, 0, 1, 1, 0, 0, 0, 1, 32'h0000_007F, 1);
        run("R6 u half", 32'h0001_2345, 2, 1, 0, 0, 0, 0, 0, 1, 32'h0000_FFFF, 1);
        run("R6 u src s dst", 32'h0000_0005, 2, 0, 0, 1, 0, 0, 0, 1, 32'h0000_0005, 1);
        run("R6 u src s dst big", 32'hFFFF_FFF0, 2, 0, 0, 1, 0, 0, 0, 1, 32'h0000_007F, 1);
        run("R6 u word dst", 32'h0000_ABCD, 1, 2, 0, 0, 0, 0, 0, 1, 32'h0000_ABCD, 1);
        // R7: wrapping
        run("R7 mask signed byte", 32'hFFFF_FF80, 2, 0, 1, 1, 0, 0, 0, 0, 32'h0000_0080, 1);
        run("R7 mask half", 32'h1234_5678, 2, 1, 0, 0, 0, 0, 0, 0, 32'h0000_5678, 1);
        // R8: error fallback
        run("R8 long src", 32'h0000_1234, 3, 2, 0, 0, 0, 0, 0, 0, 32'h0000_1234, 1);
        run("R8 bad half sel", 32'h1234_5678, 1, 2, 0, 0, 1, 0, 0, 0, 32'h0000_5678, 1);
        run("R8 bad word sel", 32'h1234_5678, 2, 2, 0, 0, 2, 0, 0, 0, 32'h1234_5678, 1);
        // R9: zero and sign flags
        run("R9 zero result", 32'h0000_0100, 2, 0, 0, 0, 0, 0, 0, 0, 32'h0000_0000, 1);
        run("R9 negative result", 32'h0000_0001, 2, 2, 1, 1, 0, 0, 1, 0, 32'hFFFF_FFFF, 1);

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] op;
            logic [1:0] s, d, sel;
            logic ss, ds, ab, ng, st;
            op = $urandom;
            case ($urandom_range(0, 3))
                0: op = {{24{op[7]}}, op[7:0]};
                1: op = op & 32'h0000_FFFF;
                default: ;
            endcase
            s = 2'($urandom_range(0, 3)); d = 2'($urandom_range(0, 3)); sel = 2'($urandom_range(0, 3));
            ss = 1'($urandom); ds = 1'($urandom); ab = 1'($urandom); ng = 1'($urandom); st = 1'($urandom);
            run(tag_of(ss, ds, st, s, d), op, s, d, ss, ds, sel, ab, ng, st, 32'd0, 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule